// File: doc/BRIEF.md
# PHY Management Register Translator

This block answers clause-22 style PHY management requests for two internal PHYs by turning them into single accesses on the switch's internal 16-bit register bus. A request carries a PHY index, a 5-bit register number, a direction flag and write data. It is accepted with a valid/ready handshake, and the block answers with a one-cycle response pulse that carries read data and an error flag.

The switch keeps the PHY registers in its own address space. Each PHY has a block of registers, and the block of the second PHY sits 0x0C above that of the first. The hardware stores the two identifier words in swapped order, so the translator maps them crosswise to undo the swap. The interrupt-status register does not exist in the switch. The translator returns a fixed value for it. Registers the switch does not implement read as zero. Writes go through only for the control and advertisement registers. A port strapped as fiber takes no PHY writes at all.

Only one request is in flight at a time. Requests that need no bus access are answered in the cycle after acceptance. Requests that use the bus are answered in the cycle after the bus acknowledges.

Top module: `phy_reg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `bus_req` are 0.
- R2: A read of register 0, 1, 4 or 5 issues one bus read at address 0x4C + 2*reg for PHY 0, and 0x0C higher for PHY 1. The response returns `bus_rdata` with `rsp_err` = 0.
- R3: A read of register 2 issues a bus read at 0x52, and a read of register 3 issues a bus read at 0x50. For PHY 1 both addresses are 0x0C higher.
- R4: A read of register 27 (0x1B) returns 0x0505 with `rsp_err` = 0 and no bus access.
- R5: A read of any register number not named in R2 to R4 returns 0 with `rsp_err` = 0 and no bus access.
- R6: A write to register 0 or 4 issues one bus write (`bus_we` = 1) at the R2 address with `req_wdata`. It then responds with `rsp_rdata` = 0 and `rsp_err` = 0.
- R7: A write to any other register completes with `rsp_err` = 0 and no bus access.
- R8: Bit i of `port_fiber` marks PHY i as fiber, and the block samples it in the acceptance cycle. A write to a fiber PHY completes with `rsp_err` = 0 and no bus access. Reads of a fiber PHY behave as in R2 to R5. A change of `port_fiber` after acceptance does not affect the request.
- R9: A PHY index of 2 or more, read or write, completes with `rsp_err` = 1, `rsp_rdata` = 0 and no bus access.
- R10: If `bus_err` is 1 together with `bus_ack`, the response has `rsp_err` = 1 and `rsp_rdata` = 0, whatever `bus_rdata` holds.
- R11: `req_ready` stays 0 from the cycle after acceptance through the response cycle, and returns to 1 in the cycle after. `rsp_valid` lasts exactly one cycle. It comes one cycle after acceptance when no bus access is needed, and one cycle after `bus_ack` otherwise.
- R12: `bus_req` stays 1 with stable `bus_addr`, `bus_we` and `bus_wdata` until the cycle in which `bus_ack` is 1. It drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_phy | input | 3 | PHY index |
| req_reg | input | 5 | Management register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| port_fiber | input | 2 | Per-PHY fiber flag, bit i for PHY i |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Request failed |
| bus_req | output | 1 | Internal bus access pending |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 16 | Internal bus byte address |
| bus_wdata | output | 16 | Internal bus write data |
| bus_ack | input | 1 | Internal bus completion |
| bus_rdata | input | 16 | Internal bus read data |
| bus_err | input | 1 | Internal bus error with completion |

## Verification
Two events can fall in the same cycle: a change of the fiber strap and the acceptance of a write to that port. The bench provokes this by holding one fiber value at the acceptance edge and flipping it in the very next cycle. It judges the result only by whether a bus write appears. A bus error can also arrive together with non-zero read data in the acknowledging cycle. The bench then requires a zero data word and a raised error flag in the response.

// File: rtl/phy_xlate_pkg.sv
package phy_xlate_pkg;

  // What one accepted request turns into
  typedef enum logic [1:0] {
    ACT_LOCAL  = 2'd0,   // answered without a bus cycle
    ACT_BUS_RD = 2'd1,
    ACT_BUS_WR = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // Clause-22 register numbers the translator recognises
  localparam int unsigned MREG_CTRL   = 0;
  localparam int unsigned MREG_STAT   = 1;
  localparam int unsigned MREG_ID_HI  = 2;
  localparam int unsigned MREG_ID_LO  = 3;
  localparam int unsigned MREG_ADV    = 4;
  localparam int unsigned MREG_LPA    = 5;

endpackage

// File: rtl/phy_reg_decode.sv
module phy_reg_decode
  import phy_xlate_pkg::*;
#(
  parameter int unsigned NUM_PHY     = 2,
  parameter int unsigned PHY_IDX_W   = 3,
  parameter int unsigned REG_W       = 5,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CTRL_BASE   = 'h4C,
  parameter int unsigned PHY_STRIDE  = 'h0C,
  parameter int unsigned ID_HI_ADDR  = 'h52,
  parameter int unsigned ID_LO_ADDR  = 'h50,
  parameter int unsigned IRQ_REG     = 'h1B,
  parameter int unsigned IRQ_VALUE   = 'h0505
) (
  input  logic [PHY_IDX_W-1:0] phy_idx,
  input  logic [REG_W-1:0]     reg_num,
  input  logic                 is_write,
  input  logic [NUM_PHY-1:0]   fiber,
  output act_e                 act,
  output logic [ADDR_W-1:0]    addr,
  output logic [DATA_W-1:0]    local_data,
  output logic                 local_err
);

  localparam int unsigned ID_HI_OFS = ID_HI_ADDR - CTRL_BASE;
  localparam int unsigned ID_LO_OFS = ID_LO_ADDR - CTRL_BASE;

  logic [ADDR_W-1:0] phy_off [NUM_PHY];

  // Per-PHY register-block offsets
  for (genvar g = 0; g < NUM_PHY; g++) begin : g_off
    assign phy_off[g] = ADDR_W'(g * PHY_STRIDE);
  end

  logic              phy_ok;
  logic              fiber_hit;
  logic [ADDR_W-1:0] sel_off;
  logic [ADDR_W-1:0] blk_base;

  always_comb begin
    phy_ok    = (32'(phy_idx) < NUM_PHY);
    fiber_hit = 1'b0;
    sel_off   = '0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (phy_idx == PHY_IDX_W'(i)) begin
        fiber_hit = fiber[i];
        sel_off   = phy_off[i];
      end
    end
    blk_base = sel_off + ADDR_W'(CTRL_BASE);
  end

  always_comb begin
    act        = ACT_LOCAL;
    addr       = blk_base + ADDR_W'({reg_num, 1'b0});
    local_data = '0;
    local_err  = 1'b0;
    if (!phy_ok) begin
      local_err = 1'b1;
    end else if (is_write) begin
      if (!fiber_hit &&
          (reg_num == REG_W'(MREG_CTRL) || reg_num == REG_W'(MREG_ADV)))
        act = ACT_BUS_WR;
    end else begin
      case (32'(reg_num))
        MREG_CTRL, MREG_STAT, MREG_ADV, MREG_LPA: act = ACT_BUS_RD;
        MREG_ID_HI: begin
          act  = ACT_BUS_RD;
          addr = blk_base + ADDR_W'(ID_HI_OFS);
        end
        MREG_ID_LO: begin
          act  = ACT_BUS_RD;
          addr = blk_base + ADDR_W'(ID_LO_OFS);
        end
        IRQ_REG:  local_data = DATA_W'(IRQ_VALUE);
        default:  local_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/phy_bus_seq.sv
module phy_bus_seq
  import phy_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  act_e              act,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] local_data,
  input  logic              local_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);

  seq_state_e state;

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (act == ACT_LOCAL) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= local_data;
              rsp_err   <= local_err;
              state     <= ST_DONE;
            end else begin
              bus_req   <= 1'b1;
              bus_we    <= (act == ACT_BUS_WR);
              bus_addr  <= dec_addr;
              bus_wdata <= (act == ACT_BUS_WR) ? wdata : '0;
              state     <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (bus_ack) begin
            bus_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= bus_err;
            rsp_rdata <= (bus_err || bus_we) ? '0 : bus_rdata;
            state     <= ST_DONE;
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)); // R12
  AST_BUS_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req && rsp_valid); // R12
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_rdata == '0); // R10
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (bus_req || rsp_valid) |-> !req_ready); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R11

endmodule

// File: rtl/phy_reg_xlate.sv
module phy_reg_xlate
  import phy_xlate_pkg::*;
#(
  parameter int unsigned NUM_PHY    = 2,
  parameter int unsigned PHY_IDX_W  = 3,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CTRL_BASE  = 'h4C,
  parameter int unsigned PHY_STRIDE = 'h0C,
  parameter int unsigned ID_HI_ADDR = 'h52,
  parameter int unsigned ID_LO_ADDR = 'h50,
  parameter int unsigned IRQ_REG    = 'h1B,
  parameter int unsigned IRQ_VALUE  = 'h0505
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PHY_IDX_W-1:0] req_phy,
  input  logic [REG_W-1:0]     req_reg,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [NUM_PHY-1:0]   port_fiber,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_ack,
  input  logic [DATA_W-1:0]    bus_rdata,
  input  logic                 bus_err
);

  act_e              dec_act;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_data;
  logic              dec_err;

  phy_reg_decode #(
    .NUM_PHY(NUM_PHY), .PHY_IDX_W(PHY_IDX_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_BASE(CTRL_BASE),
    .PHY_STRIDE(PHY_STRIDE), .ID_HI_ADDR(ID_HI_ADDR),
    .ID_LO_ADDR(ID_LO_ADDR), .IRQ_REG(IRQ_REG), .IRQ_VALUE(IRQ_VALUE)
  ) i_decode (
    .phy_idx    (req_phy),
    .reg_num    (req_reg),
    .is_write   (req_write),
    .fiber      (port_fiber),
    .act        (dec_act),
    .addr       (dec_addr),
    .local_data (dec_data),
    .local_err  (dec_err)
  );

  phy_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .act        (dec_act),
    .dec_addr   (dec_addr),
    .wdata      (req_wdata),
    .local_data (dec_data),
    .local_err  (dec_err),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err)
  );

  // A request that is refused must never reach the bus
  AST_BAD_PHY_LOCAL: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (32'(req_phy) >= NUM_PHY) |=> !bus_req && rsp_valid && rsp_err); // R9

endmodule

// File: tb/test_phy_reg_xlate.sv
module test_phy_reg_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  port_fiber = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        bus_req;
  logic        bus_we;
  logic [15:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic        bus_err = 1'b0;

  int checks = 0;
  int errors = 0;

  // Observations of the last request
  int          n_bus;
  logic [15:0] s_addr;
  logic        s_we;
  logic [15:0] s_wdata;
  logic [15:0] s_rdata;
  logic        s_err;
  int          s_lat;
  bit          s_ready_low;
  bit          s_stable;
  bit          s_ready_back;

  always #10 clk = ~clk;   // 50 MHz

  phy_reg_xlate i_phy_reg_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_phy(req_phy), .req_reg(req_reg), .req_write(req_write),
    .req_wdata(req_wdata), .port_fiber(port_fiber), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one request and play the bus side with a given delay and answer
  task automatic do_req(input int phy, input int rg, input bit wr,
                        input logic [15:0] wd, input logic [1:0] f_acc,
                        input logic [1:0] f_after, input int dly,
                        input logic [15:0] brd, input bit berr);
    int  waited = 0;
    int  guard  = 0;
    bit  done   = 0;
    n_bus = 0; s_addr = '0; s_we = 0; s_wdata = '0; s_rdata = '1; s_err = 1'bx;
    s_lat = 0; s_ready_low = 1; s_stable = 1; s_ready_back = 0;
    @(negedge clk);
    req_valid  = 1'b1;
    req_phy    = 3'(phy);
    req_reg    = 5'(rg);
    req_write  = wr;
    req_wdata  = wd;
    port_fiber = f_acc;
    @(posedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
    port_fiber = f_after;
    while (!done && guard < 60) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
      if (rsp_valid) begin
        s_rdata = rsp_rdata;
        s_err   = rsp_err;
        if (req_ready) s_ready_low = 0;
        done = 1;
      end else begin
        if (req_ready) s_ready_low = 0;
        if (bus_req) begin
          if (waited == 0) begin
            n_bus++;
            s_addr = bus_addr; s_we = bus_we; s_wdata = bus_wdata;
          end else if (bus_addr !== s_addr || bus_wdata !== s_wdata || bus_we !== s_we) begin
            s_stable = 0;
          end
          if (waited == dly) begin
            bus_ack   = 1'b1;
            bus_rdata = brd;
            bus_err   = berr;
          end
          waited++;
        end
        s_lat++;
        @(negedge clk);
        guard++;
      end
    end
    bus_ack = 1'b0;
    bus_err = 1'b0;
    if (!done) begin
      errors++;
      $display("FAIL R11 no response actual none expected rsp_valid");
    end
    @(negedge clk);
    s_ready_back = req_ready && !rsp_valid;
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 bus_req", 32'(bus_req), 0);
  endtask

  task automatic t_mapped_reads;
    int regs [4] = '{0, 1, 4, 5};
    for (int p = 0; p < 2; p++) begin
      foreach (regs[k]) begin
        do_req(p, regs[k], 0, 16'h0, 2'b00, 2'b00, k, 16'h1234 + 16'(k) + 16'(p*16), 0);
        chk("R2 bus count", 32'(n_bus), 1);
        chk("R2 addr", 32'(s_addr), 32'('h4C + 2*regs[k] + p*'h0C));
        chk("R2 we", 32'(s_we), 0);
        chk("R2 data", 32'(s_rdata), 32'(16'h1234 + 16'(k) + 16'(p*16)));
        chk("R2 err", 32'(s_err), 0);
        chk("R12 stable", 32'(s_stable), 1);
        chk("R11 ready low", 32'(s_ready_low), 1);
        chk("R11 ready back", 32'(s_ready_back), 1);
      end
    end
  endtask

  task automatic t_id_swap;
    for (int p = 0; p < 2; p++) begin
      do_req(p, 2, 0, 16'h0, 2'b00, 2'b00, 0, 16'h0022, 0);
      chk("R3 id2 addr", 32'(s_addr), 32'('h52 + p*'h0C));
      chk("R3 id2 data", 32'(s_rdata), 32'h0022);
      do_req(p, 3, 0, 16'h0, 2'b00, 2'b00, 1, 16'h1430, 0);
      chk("R3 id3 addr", 32'(s_addr), 32'('h50 + p*'h0C));
      chk("R3 id3 data", 32'(s_rdata), 32'h1430);
    end
  endtask

  task automatic t_irq_const;
    for (int p = 0; p < 2; p++) begin
      do_req(p, 27, 0, 16'h0, 2'b00, 2'b00, 0, 16'hDEAD, 0);
      chk("R4 value", 32'(s_rdata), 32'h0505);
      chk("R4 err", 32'(s_err), 0);
      chk("R4 no bus", 32'(n_bus), 0);
      chk("R11 local latency", 32'(s_lat), 0);
    end
  endtask

  task automatic t_other_reads;
    int regs [5] = '{6, 9, 16, 26, 31};
    foreach (regs[k]) begin
      do_req(k % 2, regs[k], 0, 16'h0, 2'b00, 2'b00, 0, 16'hBEEF, 0);
      chk("R5 zero", 32'(s_rdata), 0);
      chk("R5 err", 32'(s_err), 0);
      chk("R5 no bus", 32'(n_bus), 0);
    end
  endtask

  task automatic t_writes;
    do_req(0, 0, 1, 16'h3100, 2'b00, 2'b00, 2, 16'hFFFF, 0);
    chk("R6 ctrl bus", 32'(n_bus), 1);
    chk("R6 ctrl addr", 32'(s_addr), 32'h4C);
    chk("R6 ctrl we", 32'(s_we), 1);
    chk("R6 ctrl wdata", 32'(s_wdata), 32'h3100);
    chk("R6 ctrl rdata", 32'(s_rdata), 0);
    chk("R6 ctrl err", 32'(s_err), 0);
    chk("R12 write stable", 32'(s_stable), 1);
    do_req(1, 4, 1, 16'h01E1, 2'b00, 2'b00, 0, 16'h0, 0);
    chk("R6 adv addr", 32'(s_addr), 32'h60);
    chk("R6 adv wdata", 32'(s_wdata), 32'h01E1);
    chk("R6 adv we", 32'(s_we), 1);
    for (int r = 1; r < 32; r += 3) begin
      if (r == 4) continue;
      do_req(r % 2, r, 1, 16'hA5A5, 2'b00, 2'b00, 0, 16'h0, 0);
      chk("R7 no bus", 32'(n_bus), 0);
      chk("R7 err", 32'(s_err), 0);
    end
  endtask

  task automatic t_fiber;
    // strap set at acceptance, cleared right after
    do_req(1, 0, 1, 16'h8000, 2'b10, 2'b00, 0, 16'h0, 0);
    chk("R8 fiber write dropped", 32'(n_bus), 0);
    chk("R8 fiber write err", 32'(s_err), 0);
    // strap clear at acceptance, set right after
    do_req(0, 4, 1, 16'h0061, 2'b00, 2'b01, 0, 16'h0, 0);
    chk("R8 copper write sent", 32'(n_bus), 1);
    chk("R8 copper write addr", 32'(s_addr), 32'h54);
    // only the addressed PHY's strap counts
    do_req(0, 0, 1, 16'h1200, 2'b10, 2'b10, 0, 16'h0, 0);
    chk("R8 other port strap", 32'(n_bus), 1);
    // reads of a fiber port still go out
    do_req(0, 1, 0, 16'h0, 2'b11, 2'b11, 0, 16'h7809, 0);
    chk("R8 fiber read bus", 32'(n_bus), 1);
    chk("R8 fiber read data", 32'(s_rdata), 32'h7809);
  endtask

  task automatic t_bad_phy;
    for (int p = 2; p < 8; p += 5) begin
      do_req(p, 0, 0, 16'h0, 2'b00, 2'b00, 0, 16'hFFFF, 0);
      chk("R9 read err", 32'(s_err), 1);
      chk("R9 read data", 32'(s_rdata), 0);
      chk("R9 read no bus", 32'(n_bus), 0);
      do_req(p, 4, 1, 16'h1111, 2'b11, 2'b11, 0, 16'h0, 0);
      chk("R9 write err", 32'(s_err), 1);
      chk("R9 write no bus", 32'(n_bus), 0);
    end
  endtask

  task automatic t_bus_error;
    do_req(1, 5, 0, 16'h0, 2'b00, 2'b00, 3, 16'hC3C3, 1);
    chk("R10 err", 32'(s_err), 1);
    chk("R10 data zero", 32'(s_rdata), 0);
    chk("R10 bus used", 32'(n_bus), 1);
    chk("R11 bus latency", 32'(s_lat), 4);
    do_req(0, 0, 1, 16'h0100, 2'b00, 2'b00, 0, 16'h5555, 1);
    chk("R10 write err", 32'(s_err), 1);
    chk("R10 write data", 32'(s_rdata), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mapped_reads();
    t_id_swap();
    t_irq_const();
    t_other_reads();
    t_writes();
    t_fiber();
    t_bad_phy();
    t_bus_error();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule